// File: doc/BRIEF.md
# Integer ALU with Trapping and Non-Trapping Arithmetic

This block is the purely combinational arithmetic and logic unit of a 32-bit integer datapath. It takes two operands, which upstream logic has already widened to 32 bits, and a 4-bit operation code. In the same cycle it returns a 32-bit result, a flag that is set when the result is all zeros, and a signed-overflow flag.

Signed add and subtract raise the overflow flag when the two's-complement result does not fit in 32 bits. Their unsigned counterparts compute the same sum or difference but never raise the flag. Two compare operations, one signed and one unsigned, return a single less-than bit in bit 0 of the result. The zero flag serves as the equality test for a branch unit that subtracts its operands.

Internally a small decoder turns the code into a control struct. A datapath built on a grouped carry-lookahead adder then uses that struct to pick the result.

Top module: `int_alu`

## Requirements
- R1: Codes 0x0 (signed add) and 0x1 (unsigned add) give srcA + srcB modulo 2^32.
- R2: Codes 0x2 (signed subtract) and 0x3 (unsigned subtract) give srcA − srcB modulo 2^32, formed as srcA plus the inverse of srcB with a carry-in of 1.
- R3: Code 0x4 gives bitwise AND, 0x5 bitwise OR, 0x6 bitwise XOR and 0x7 bitwise NOR of the two operands.
- R4: Code 0xA puts 1 in bit 0 when srcA < srcB as signed two's-complement numbers, and 0 otherwise. Bits 31..1 are 0. The answer stays correct when the internal difference overflows.
- R5: Code 0xB puts 1 in bit 0 when srcA < srcB as unsigned numbers, and 0 otherwise. Bits 31..1 are 0.
- R6: isZero is 1 exactly when all 32 result bits are 0.
- R7: For codes 0x0 and 0x2, ovfFlag is 1 exactly when the signed result does not fit in 32 bits, that is, when the carry into bit 31 differs from the carry out of bit 31.
- R8: For every code other than 0x0 and 0x2, ovfFlag is 0. This includes 0x1 and 0x3 even when their operands would overflow a signed operation.
- R9: Codes 0x8, 0x9 and 0xC to 0xF give a result of 0, isZero = 1 and ovfFlag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| opSel | input | 4 | Operation code |
| aluOut | output | 32 | Result |
| isZero | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The bench drives the signed edge values 0x7FFFFFFF and 0x80000000 through every code, because those values expose the corner cases.

- An overflow flag taken from the sign bit alone would either miss the overflow or report a false one.
- A signed compare built from the sign of the difference alone would answer wrongly for 0x80000000 against 1.
- An unsigned compare that read the carry with the wrong polarity would invert every answer.

It also checks two further cases. First, it drives overflowing operands on the unsigned codes, so a design that forgot to suppress the flag there would trap. Second, it drives all six unused codes, where a default that passed the adder output through would give a non-zero result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'h0;
  localparam logic [OP_W-1:0] OP_ADDU = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OP_SUBU = 4'h3;
  localparam logic [OP_W-1:0] OP_AND  = 4'h4;
  localparam logic [OP_W-1:0] OP_OR   = 4'h5;
  localparam logic [OP_W-1:0] OP_XOR  = 4'h6;
  localparam logic [OP_W-1:0] OP_NOR  = 4'h7;
  localparam logic [OP_W-1:0] OP_SLT  = 4'hA;
  localparam logic [OP_W-1:0] OP_SLTU = 4'hB;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOR,
    SEL_SLT,
    SEL_SLTU,
    SEL_NONE
  } resSel_e;

  typedef struct packed {
    logic    invB;     // subtract: invert B and carry in 1
    logic    trapOvf;  // report signed overflow
    resSel_e resSel;   // result source
  } aluCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_NONE};
    unique case (opSel)
      OP_ADD:  ctrl = '{invB: 1'b0, trapOvf: 1'b1, resSel: SEL_SUM};
      OP_ADDU: ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_SUM};
      OP_SUB:  ctrl = '{invB: 1'b1, trapOvf: 1'b1, resSel: SEL_SUM};
      OP_SUBU: ctrl = '{invB: 1'b1, trapOvf: 1'b0, resSel: SEL_SUM};
      OP_AND:  ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_AND};
      OP_OR:   ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_OR};
      OP_XOR:  ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_XOR};
      OP_NOR:  ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_NOR};
      OP_SLT:  ctrl = '{invB: 1'b1, trapOvf: 1'b0, resSel: SEL_SLT};
      OP_SLTU: ctrl = '{invB: 1'b1, trapOvf: 1'b0, resSel: SEL_SLTU};
      default: ctrl = '{invB: 1'b0, trapOvf: 1'b0, resSel: SEL_NONE};
    endcase
  end

  // R8
  always_comb begin
    trap_scope_chk: assert (!ctrl.trapOvf || opSel == OP_ADD || opSel == OP_SUB);
  end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryMsb,
  output logic             carryOut
);

  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prp;
  logic [WIDTH:0]   carry;
  logic [NGRP:0]    grpC;

  assign gen     = addA & addB;
  assign prp     = addA | addB;
  assign grpC[0] = carryIn;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int BASE = gi * GROUP;
    logic             grpGen;
    logic             grpPrp;
    logic [GROUP-1:0] lc;

    // group generate / propagate, feeding the carry chain between groups
    always_comb begin
      grpGen = 1'b0;
      grpPrp = 1'b1;
      for (int k = 0; k < GROUP; k++) begin
        grpGen = gen[BASE+k] | (prp[BASE+k] & grpGen);
        grpPrp = grpPrp & prp[BASE+k];
      end
    end

    assign grpC[gi+1] = grpGen | (grpPrp & grpC[gi]);

    // bit carries inside the group from the group carry-in
    always_comb begin
      lc[0] = grpC[gi];
      for (int k = 1; k < GROUP; k++) begin
        lc[k] = gen[BASE+k-1] | (prp[BASE+k-1] & lc[k-1]);
      end
    end

    assign carry[BASE +: GROUP] = lc;
  end

  assign carry[WIDTH] = grpC[NGRP];
  assign sum          = addA ^ addB ^ carry[WIDTH-1:0];
  assign carryMsb     = carry[WIDTH-1];
  assign carryOut     = carry[WIDTH];

  // R1
  always_comb begin
    adder_sum_chk: assert ({carryOut, sum} == ({1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn}));
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] aluOut,
  output logic             isZero,
  output logic             ovfFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] effB;
  logic [WIDTH-1:0] sum;
  logic             carryMsb;
  logic             carryOut;
  logic             ovfRaw;
  logic             lessSigned;
  logic             lessUnsigned;

  assign effB = ctrl.invB ? ~srcB : srcB;

  int_alu_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_adder (
    .addA    (srcA),
    .addB    (effB),
    .carryIn (ctrl.invB),
    .sum     (sum),
    .carryMsb(carryMsb),
    .carryOut(carryOut)
  );

  assign ovfRaw       = carryMsb ^ carryOut;
  assign lessSigned   = sum[MSB] ^ ovfRaw;
  assign lessUnsigned = ~carryOut;

  always_comb begin
    unique case (ctrl.resSel)
      SEL_SUM:  aluOut = sum;
      SEL_AND:  aluOut = srcA & srcB;
      SEL_OR:   aluOut = srcA | srcB;
      SEL_XOR:  aluOut = srcA ^ srcB;
      SEL_NOR:  aluOut = ~(srcA | srcB);
      SEL_SLT:  aluOut = {{MSB{1'b0}}, lessSigned};
      SEL_SLTU: aluOut = {{MSB{1'b0}}, lessUnsigned};
      default:  aluOut = '0;
    endcase
  end

  assign ovfFlag = ctrl.trapOvf & ovfRaw;
  assign isZero  = ~|aluOut;

  // R2
  always_comb begin
    if (ctrl.resSel == SEL_SUM && ctrl.invB)
      diff_value_chk: assert (aluOut == srcA - srcB);
  end

  // R7
  always_comb begin
    if (ovfFlag)
      ovf_sign_chk: assert (aluOut[MSB] != srcA[MSB]);
  end

  // R4
  always_comb begin
    if (ctrl.resSel == SEL_SLT)
      slt_value_chk: assert (aluOut == {{MSB{1'b0}}, ($signed(srcA) < $signed(srcB))});
  end

  // R5
  always_comb begin
    if (ctrl.resSel == SEL_SLTU)
      sltu_value_chk: assert (aluOut == {{MSB{1'b0}}, (srcA < srcB)});
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [OP_W-1:0]  opSel,
  output logic [WIDTH-1:0] aluOut,
  output logic             isZero,
  output logic             ovfFlag
);

  aluCtrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  int_alu_datapath #(.WIDTH(WIDTH), .GROUP(GROUP)) u_dp (
    .srcA   (srcA),
    .srcB   (srcB),
    .ctrl   (ctrl),
    .aluOut (aluOut),
    .isZero (isZero),
    .ovfFlag(ovfFlag)
  );

  // R9
  always_comb begin
    if (opSel == 4'h8 || opSel == 4'h9 || opSel >= 4'hC)
      unused_code_chk: assert (aluOut == '0 && isZero && !ovfFlag);
  end

  // R8
  always_comb begin
    no_overflow_chk: assert (!ovfFlag || opSel == OP_ADD || opSel == OP_SUB);
  end

  // R6
  always_comb begin
    if (opSel == OP_SUB && srcA == srcB)
      zero_equal_chk: assert (isZero);
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] aluOut;
  logic        isZero;
  logic        ovfFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  int_alu u_dut (
    .srcA   (srcA),
    .srcB   (srcB),
    .opSel  (opSel),
    .aluOut (aluOut),
    .isZero (isZero),
    .ovfFlag(ovfFlag)
  );

  localparam logic [31:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [31:0] MINN = 32'h8000_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  function automatic logic [33:0] refAlu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic        v;
    r = '0;
    v = 1'b0;
    case (op)
      4'h0, 4'h1: r = a + b;
      4'h2, 4'h3: r = a - b;
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r = {31'b0, ($signed(a) < $signed(b))};
      4'hB: r = {31'b0, (a < b)};
      default: r = '0;
    endcase
    if (op == 4'h0) v = (a[31] == b[31]) && (r[31] != a[31]);
    if (op == 4'h2) v = (a[31] != b[31]) && (r[31] != a[31]);
    return {r, (r == '0), v};
  endfunction

  task automatic checkOp(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [33:0] exp;
    @(negedge clk);
    srcA  = a;
    srcB  = b;
    opSel = op;
    #2;
    exp = refAlu(op, a, b);
    total++;
    if (aluOut !== exp[33:2] || isZero !== exp[1] || ovfFlag !== exp[0]) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h actual res=%h z=%b v=%b expected res=%h z=%b v=%b",
               req, op, a, b, aluOut, isZero, ovfFlag, exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic testIdle();
    // R6: idle inputs give an all-zero sum
    checkOp("R6", 4'h0, 32'h0, 32'h0);
  endtask

  task automatic testAdd();
    checkOp("R1", 4'h0, 32'd12345, 32'd6789);
    checkOp("R1", 4'h1, ONES, 32'd1);
    checkOp("R1", 4'h0, 32'hDEAD_BEEF, 32'h1234_5678);
    checkOp("R7", 4'h0, MAXP, 32'd1);
    checkOp("R7", 4'h0, MINN, ONES);
    checkOp("R7", 4'h0, MINN, MINN);
    checkOp("R7", 4'h0, MAXP, ONES);
  endtask

  task automatic testSub();
    checkOp("R2", 4'h2, 32'd100, 32'd58);
    checkOp("R2", 4'h3, 32'd0, 32'd1);
    checkOp("R7", 4'h2, MINN, 32'd1);
    checkOp("R7", 4'h2, MAXP, ONES);
    checkOp("R7", 4'h2, 32'd0, MINN);
    checkOp("R7", 4'h2, ONES, MINN);
  endtask

  task automatic testLogic();
    for (int op = 4; op < 8; op++) begin
      checkOp("R3", op[3:0], 32'h0000_3C00, 32'h0000_0D00);
      checkOp("R3", op[3:0], 32'hF0F0_A5A5, 32'h0FF0_5AA5);
    end
  endtask

  task automatic testSlt();
    checkOp("R4", 4'hA, MINN, 32'd1);
    checkOp("R4", 4'hA, MAXP, ONES);
    checkOp("R4", 4'hA, ONES, 32'd0);
    checkOp("R4", 4'hA, 32'd5, 32'd5);
    checkOp("R4", 4'hA, 32'd3, 32'd7);
    checkOp("R4", 4'hA, 32'd1, MINN);
  endtask

  task automatic testSltu();
    checkOp("R5", 4'hB, ONES, 32'd0);
    checkOp("R5", 4'hB, 32'd0, ONES);
    checkOp("R5", 4'hB, MINN, MAXP);
    checkOp("R5", 4'hB, 32'd9, 32'd9);
  endtask

  task automatic testZero();
    checkOp("R6", 4'h2, 32'h1234_5678, 32'h1234_5678);
    checkOp("R6", 4'h4, 32'hAAAA_AAAA, 32'h5555_5555);
    checkOp("R6", 4'h7, ONES, 32'd0);
  endtask

  task automatic testOvfSuppress();
    checkOp("R8", 4'h1, MAXP, 32'd1);
    checkOp("R8", 4'h1, MINN, MINN);
    checkOp("R8", 4'h3, MINN, 32'd1);
    checkOp("R8", 4'h3, MAXP, ONES);
    checkOp("R8", 4'hA, MINN, MAXP);
  endtask

  task automatic testUnused();
    logic [3:0] codes [6] = '{4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < 6; i++) begin
      checkOp("R9", codes[i], MAXP, 32'd1);
    end
  endtask

  task automatic sweepCorners();
    logic [31:0] vals [5] = '{32'd0, 32'd1, MAXP, MINN, ONES};
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          checkOp("R1-sweep", op[3:0], vals[i], vals[j]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testIdle();
    testAdd();
    testSub();
    testLogic();
    testSlt();
    testSltu();
    testZero();
    testOvfSuppress();
    testUnused();
    sweepCorners();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule